// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block is a bank of 32-bit control registers reached over a simple single-cycle, memory-mapped request bus using byte addresses and word-sized accesses. The first `NUM_ALIASED` registers each occupy a group of four consecutive words. The first word of a group is the register itself. The other three words let software set, clear or invert selected bits of that register in one write, with no read-modify-write sequence. The `NUM_PLAIN` registers that follow occupy one word each and accept only whole-word writes. The stored values are presented in parallel on `ctrl_q` so that the surrounding logic can use them.

Reset loads a fixed value into every register. It also forces a lock status bit to 1 in the aliased groups selected by `LOCK_GROUPS`. A global write mask, `WMASK`, chooses which bits any write can change. By default the mask leaves the lock bit read-only.

Every request is answered in the next cycle. Accesses that are out of range, misaligned or not word-sized return an error and change nothing.

Top module: `rbank_sct`

## Requirements
- R1: After reset, register r holds `{8'h00, r[7:0], 16'hA55A}`. In an aliased group whose bit is set in `LOCK_GROUPS`, bit `LOCK_BIT` (default 31) is also forced to 1. `ctrl_q[32*r +: 32]` always shows register r.
- R2: A write to the first word of a group, or to a plain register, replaces the bits selected by `WMASK` with the write data. Bits outside `WMASK` keep their value, and by default this covers bit 31. Without a request, no register changes.
- R3: A write to group word offset 1 (set alias) ORs the write data, limited to `WMASK`, into the register.
- R4: A write to group word offset 2 (clear alias) clears the register bits that are 1 in the write data and inside `WMASK`.
- R5: A write to group word offset 3 (toggle alias) inverts the register bits that are 1 in the write data and inside `WMASK`.
- R6: A read of any of the four words of a group returns the group's register. A read of a plain register's word returns that register.
- R7: `rsp_valid` is high exactly one cycle after `req_valid`, and it carries the error flag and read data for that request. A request issued after a write sees the updated value.
- R8: A word index (byte address shifted right by two) at or beyond `4*NUM_ALIASED+NUM_PLAIN` gives `rsp_err`=1 and `rsp_rdata`=0, and no register changes.
- R9: An access with `req_addr[1:0]`≠0 is rejected with `rsp_err`=1, `rsp_rdata`=0 and no register change. The same applies to an access whose `req_size` is not 2 (0 = byte, 1 = half, 2 = word, 3 = reserved).
- R10: An accepted write responds with `rsp_err`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (2 = word) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| ctrl_q | output | 32*(NUM_ALIASED+NUM_PLAIN) | All register values, register r at bits 32*r+31..32*r |

## Verification
The bench uses the default build: four aliased groups, four plain registers, an 8-bit byte address and lock bits in groups 0 and 2. In this build the whole 64-word address space can be swept. Every implemented word, every out-of-range index, every misaligned offset of every word and both narrow sizes are each exercised. A reference model computes the set, clear and toggle results under the write mask for fixed and random patterns. Because both locked and unlocked groups are present, the read-only lock bit is observed holding against writes of all ones and all zeros.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;

    // Order matches the word offset inside an aliased group.
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             err;
        wr_op_e           op;
        logic [SEL_W-1:0] sel;
    } dec_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input wr_op_e            op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] data,
        input logic [DATA_W-1:0] mask
    );
        logic [DATA_W-1:0] nxt;
        case (op)
            OP_SET:  nxt = cur | data;
            OP_CLR:  nxt = cur & ~data;
            OP_TOG:  nxt = cur ^ data;
            default: nxt = data;
        endcase
        return (cur & ~mask) | (nxt & mask);
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(
        input int   idx,
        input logic lock,
        input int   lock_bit
    );
        logic [DATA_W-1:0] v;
        v = {8'h00, idx[7:0], 16'hA55A};
        if (lock) v[lock_bit] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rbank_decode.sv
module rbank_decode
    import rbank_pkg::*;
#(
    parameter int NUM_ALIASED = 4,
    parameter int NUM_PLAIN   = 4,
    parameter int ADDR_W      = 8
) (
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output dec_t              dec
);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int NUM_WORDS = 4 * NUM_ALIASED + NUM_PLAIN;
    localparam int ALIAS_END = 4 * NUM_ALIASED;

    logic [IDX_W-1:0] idx;
    logic             ok;

    assign idx = req_addr[ADDR_W-1:2];

    always_comb begin
        ok = (32'(idx) < NUM_WORDS)
           && (req_addr[1:0] == 2'b00)
           && (acc_size_e'(req_size) == SZ_WORD);
        dec.err = req_valid & ~ok;
        dec.wr  = req_valid & ok & req_we;
        dec.rd  = req_valid & ok & ~req_we;
        if (32'(idx) < ALIAS_END) begin
            dec.sel = SEL_W'(idx >> 2);
            dec.op  = wr_op_e'(idx[1:0]);
        end else begin
            dec.sel = SEL_W'(32'(idx) - ALIAS_END + NUM_ALIASED);
            dec.op  = OP_WRITE;
        end
    end

endmodule

// File: rtl/rbank_cell.sv
module rbank_cell
    import rbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0,
    parameter logic [DATA_W-1:0] WMASK     = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RESET_VAL;
        else if (wr_en)
            q <= apply_op(op, q, wdata, WMASK);
    end

endmodule

// File: rtl/rbank_sct.sv
module rbank_sct
    import rbank_pkg::*;
#(
    parameter int                NUM_ALIASED = 4,
    parameter int                NUM_PLAIN   = 4,
    parameter int                ADDR_W      = 8,
    parameter logic [31:0]       LOCK_GROUPS = 32'h0000_0005,
    parameter int                LOCK_BIT    = 31,
    parameter logic [DATA_W-1:0] WMASK       = 32'h7FFF_FFFF
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    req_valid,
    input  logic                                    req_we,
    input  logic [ADDR_W-1:0]                       req_addr,
    input  logic [1:0]                              req_size,
    input  logic [DATA_W-1:0]                       req_wdata,
    output logic                                    rsp_valid,
    output logic                                    rsp_err,
    output logic [DATA_W-1:0]                       rsp_rdata,
    output logic [(NUM_ALIASED+NUM_PLAIN)*DATA_W-1:0] ctrl_q
);
    localparam int NUM_REGS = NUM_ALIASED + NUM_PLAIN;

    dec_t              dec;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DATA_W-1:0] rd_word;

    rbank_decode #(
        .NUM_ALIASED(NUM_ALIASED),
        .NUM_PLAIN  (NUM_PLAIN),
        .ADDR_W     (ADDR_W)
    ) u_dec (
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_size (req_size),
        .dec      (dec)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic LOCKED = (r < NUM_ALIASED) && LOCK_GROUPS[r % 32];
        localparam logic [DATA_W-1:0] RV = reset_word(r, LOCKED, LOCK_BIT);

        rbank_cell #(
            .RESET_VAL(RV),
            .WMASK    (WMASK)
        ) u_cell (
            .clk  (clk),
            .rst  (rst),
            .wr_en(dec.wr && (dec.sel == SEL_W'(r))),
            .op   (dec.op),
            .wdata(req_wdata),
            .q    (regs[r])
        );

        assign ctrl_q[r*DATA_W +: DATA_W] = regs[r];
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (dec.sel == SEL_W'(r)) rd_word = regs[r];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= dec.err;
            rsp_rdata <= dec.rd ? rd_word : '0;
        end
    end

endmodule

// File: rtl/rbank_sct_chk.sv
module rbank_sct_chk
    import rbank_pkg::*;
#(
    parameter int                NUM_ALIASED = 4,
    parameter int                NUM_PLAIN   = 4,
    parameter int                ADDR_W      = 8,
    parameter int                LOCK_BIT    = 31,
    parameter logic [DATA_W-1:0] WMASK       = 32'h7FFF_FFFF
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic                                     req_valid,
    input logic [ADDR_W-1:0]                        req_addr,
    input logic [1:0]                               req_size,
    input logic                                     rsp_valid,
    input logic                                     rsp_err,
    input logic [DATA_W-1:0]                        rsp_rdata,
    input logic [(NUM_ALIASED+NUM_PLAIN)*DATA_W-1:0] ctrl_q
);
    localparam int NUM_REGS  = NUM_ALIASED + NUM_PLAIN;
    localparam int NUM_WORDS = 4 * NUM_ALIASED + NUM_PLAIN;

    logic                bad_req;
    logic [NUM_REGS-1:0] lock_bits;

    assign bad_req = req_valid && ((32'(req_addr[ADDR_W-1:2]) >= NUM_WORDS)
                     || (req_addr[1:0] != 2'b00) || (req_size != 2'd2));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_lb
        assign lock_bits[r] = ctrl_q[r*DATA_W + LOCK_BIT];
    end

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R7
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R9
    bad_req_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> (rsp_err && $stable(ctrl_q)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ctrl_q));

    if (!WMASK[LOCK_BIT]) begin : g_lock
        // R2
        lock_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> $stable(lock_bits));
    end

endmodule

bind rbank_sct rbank_sct_chk #(
    .NUM_ALIASED(NUM_ALIASED),
    .NUM_PLAIN  (NUM_PLAIN),
    .ADDR_W     (ADDR_W),
    .LOCK_BIT   (LOCK_BIT),
    .WMASK      (WMASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_size (req_size),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .ctrl_q   (ctrl_q)
);

// File: tb/rbank_sct_tb.sv
module rbank_sct_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NP = 4;
    localparam int NR = NA + NP;
    localparam int NW = 4 * NA + NP;
    localparam logic [31:0] LOCKS = 32'h5;
    localparam logic [31:0] WM = 32'h7FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [1:0]    req_size = 2'd2;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic [NR*32-1:0] ctrl_q;

    int total = 0;
    int bad = 0;
    logic [31:0] model [NR];
    logic        g_err;
    logic [31:0] g_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbank_sct u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ctrl_q(ctrl_q)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int reg_of(input int w);
        return (w < 4 * NA) ? w / 4 : w - 4 * NA + NA;
    endfunction

    task automatic access(input bit we, input logic [7:0] addr, input logic [1:0] size,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_size = size; req_wdata = wd;
        @(negedge clk);
        // R7: response present one cycle after the request
        check(rsp_valid === 1'b1, "R7 rsp_valid", 32'(rsp_valid), 32'd1);
        g_err = rsp_err; g_rd = rsp_rdata;
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic check_ctrl(input string tag);
        for (int r = 0; r < NR; r++)
            check(ctrl_q[r*32 +: 32] === model[r], tag, ctrl_q[r*32 +: 32], model[r]);
    endtask

    task automatic wr_alias(input int g, input int k, input logic [31:0] d, input string tag);
        logic [31:0] nxt;
        access(1'b1, 8'((4 * g + k) * 4), 2'd2, d);
        // R10: accepted write response
        check(g_err === 1'b0 && g_rd === '0, "R10 write rsp", g_rd, 32'd0);
        case (k)
            1: nxt = model[g] | d;
            2: nxt = model[g] & ~d;
            3: nxt = model[g] ^ d;
            default: nxt = d;
        endcase
        model[g] = (model[g] & ~WM) | (nxt & WM);
        access(1'b0, 8'(4 * g * 4), 2'd2, 32'd0);
        check(g_err === 1'b0 && g_rd === model[g], tag, g_rd, model[g]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        void'($urandom(32'd11));
        for (int r = 0; r < NR; r++) begin
            model[r] = {8'h00, 8'(r), 16'hA55A};
            if (r < NA && LOCKS[r]) model[r][31] = 1'b1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R7 idle after reset", 32'(rsp_valid), 32'd0);
        check_ctrl("R1 reset value");

        // R6: every implemented word reads its base register
        for (int w = 0; w < NW; w++) begin
            access(1'b0, 8'(w * 4), 2'd2, 32'd0);
            check(g_err === 1'b0 && g_rd === model[reg_of(w)], "R6 alias read",
                  g_rd, model[reg_of(w)]);
        end

        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hAAAA_AAAA; pats[3] = 32'h5555_5555;
        pats[4] = $urandom;      pats[5] = $urandom;
        for (int g = 0; g < NA; g++) begin
            for (int p = 0; p < 6; p++) begin
                wr_alias(g, 1, pats[p], "R3 set alias");
                wr_alias(g, 2, pats[(p + 2) % 6], "R4 clear alias");
                wr_alias(g, 3, pats[(p + 3) % 6] ^ 32'h0F0F_00FF, "R5 toggle alias");
                wr_alias(g, 0, pats[(p + 1) % 6], "R2 base write");
                check_ctrl("R2 ctrl_q mirror");
            end
            for (int k = 0; k < 4; k++) begin
                access(1'b0, 8'((4 * g + k) * 4), 2'd2, 32'd0);
                check(g_rd === model[g], "R6 alias read after writes", g_rd, model[g]);
            end
        end

        // R2: plain registers, including all-ones and all-zeros against bit 31
        for (int p = 0; p < NP; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic [31:0] d;
                d = (n == 0) ? 32'hFFFF_FFFF : (n == 1) ? 32'h0 : $urandom;
                access(1'b1, 8'((4 * NA + p) * 4), 2'd2, d);
                model[NA + p] = (model[NA + p] & ~WM) | (d & WM);
                access(1'b0, 8'((4 * NA + p) * 4), 2'd2, 32'd0);
                check(g_rd === model[NA + p], "R2 plain write", g_rd, model[NA + p]);
            end
        end

        // R8: sweep all out-of-range word indices
        for (int w = NW; w < 64; w++) begin
            access(1'b1, 8'(w * 4), 2'd2, 32'hFFFF_FFFF);
            check(g_err === 1'b1 && g_rd === '0, "R8 range write", g_rd, 32'd0);
            access(1'b0, 8'(w * 4), 2'd2, 32'd0);
            check(g_err === 1'b1 && g_rd === '0, "R8 range read", g_rd, 32'd0);
        end
        check_ctrl("R8 no change");

        // R9: misaligned offsets and narrow sizes on every implemented word
        for (int w = 0; w < NW; w++) begin
            for (int o = 1; o < 4; o++) begin
                access(1'b1, 8'(w * 4 + o), 2'd2, 32'h7FFF_FFFF);
                check(g_err === 1'b1 && g_rd === '0, "R9 misaligned", 32'(g_err), 32'd1);
            end
            for (int s = 0; s < 4; s++) begin
                if (s == 2) continue;
                access(1'b1, 8'(w * 4), 2'(s), 32'h1234_5678);
                check(g_err === 1'b1, "R9 bad size write", 32'(g_err), 32'd1);
                access(1'b0, 8'(w * 4), 2'(s), 32'd0);
                check(g_err === 1'b1 && g_rd === '0, "R9 bad size read", g_rd, 32'd0);
            end
        end
        check_ctrl("R9 no change");

        for (int w = 0; w < NW; w++) begin
            access(1'b0, 8'(w * 4), 2'd2, 32'd0);
            check(g_rd === model[reg_of(w)], "R6 final sweep", g_rd, model[reg_of(w)]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule